// File: doc/BRIEF.md
# Control/Status Register Access Permission Checker

This block sits in the register-access stage of a processor pipeline and decides whether an access to a control/status register may go ahead. It takes the 12-bit register address, the current privilege level, a flag marking accesses made on behalf of an external debugger, and the few status and enable fields the rules depend on. One clock cycle later it reports whether the access is illegal and, if so, why. It also reports whether the access must mark the floating-point state as dirty.

Three rules are enforced:
- Floating-point rule: the floating-point registers are closed while floating-point state is switched off.
- Counter rule: the counter registers are gated by two enable masks that depend on the privilege level.
- Translation rule: the address-translation register traps from supervisor mode while translation trapping is on.

The address sets of the three rules do not overlap. The fixed reason-code priority therefore only matters for the order in which the rules are evaluated. Decoding of the rest of the register map, the register storage and trap entry belong to neighbouring blocks.

Top module: `csr_perm_chk`

## Requirements
- R1: After a cycle with `rst_n` low, all outputs (`chk_valid`, `chk_illegal`, `chk_reason`, `fs_set_dirty`) are 0.
- R2: An access to address 0x001, 0x002 or 0x003 with `status_fs` equal to 2'b00 and `dbg_access` low is reported illegal with reason 1.
- R3: With `dbg_access` high, an access to 0x001..0x003 is legal whatever `status_fs` holds.
- R4: For addresses 0xC00..0xC1F, the index is address bits [4:0]. The enable mask is all ones, ANDed with `mcnt_en` when `priv` is 0 or 1, and also ANDed with `scnt_en` when `priv` is 0. The access is illegal with reason 2 when the indexed mask bit is 0.
- R5: With XLEN = 32, addresses 0xC80..0xC9F follow the same counter rule using address bits [4:0]. With XLEN = 64 they are not counter registers.
- R6: An access to 0x180 with `priv` = 1 and `status_tvm` high is illegal with reason 3. With `priv` = 0, or with `status_tvm` low, the access is legal.
- R7: With `priv` equal to 2 or 3 (both machine), the counter and translation rules never reject an access.
- R8: `fs_set_dirty` is 1 exactly for a legal write (`acc_write` high) to 0x001..0x003.
- R9: The outputs reflect the access presented one cycle earlier. A cycle with `acc_valid` low gives all outputs 0. An address outside the three rule sets is legal with reason 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | The access writes the register |
| acc_addr | input | 12 | Register address |
| priv | input | 2 | Privilege: 0 user, 1 supervisor, 2 or 3 machine |
| dbg_access | input | 1 | Access issued by the debugger |
| status_fs | input | 2 | Floating-point state field, 2'b00 means off |
| status_tvm | input | 1 | Trap translation-register access from supervisor |
| mcnt_en | input | 32 | Machine-level counter enable mask |
| scnt_en | input | 32 | Supervisor-level counter enable mask |
| chk_valid | output | 1 | Result below is for the previous cycle's access |
| chk_illegal | output | 1 | Access is illegal |
| chk_reason | output | 2 | 0 legal, 1 FP off, 2 counter disabled, 3 translation trap |
| fs_set_dirty | output | 1 | Set the floating-point state field to dirty (2'b11) |

## Verification
Random accesses aim at each address class in turn:
- Floating-point registers, with the state field either off or on and the debugger flag either set or clear. This separates a plain floating-point denial from a debugger bypass.
- Counter registers, with random enable masks at every privilege level. This separates the machine mask from the supervisor mask and from machine-mode immunity.
- Low and high counter halves, which exercise the width-dependent range.
- The translation register at user, supervisor and both machine encodings, with the trap flag either set or clear.

Directed cases pin down the following:
- A counter that only one of the two masks disables.
- Index 31 at the top of each counter range.
- Privilege encoding 2.
- Reads as opposed to writes for the dirty flag.
- Idle cycles between accesses.

// File: rtl/csr_perm_pkg.sv
// Package: shared constants and types for the register access permission checker.
// Assumes a 12-bit register address space and a 2-bit privilege encoding.
package csr_perm_pkg;

    localparam int ADDR_W = 12;
    localparam int PRIV_W = 2;

    // Privilege encodings; anything at or above PRIV_M_MIN counts as machine.
    localparam logic [PRIV_W-1:0] PRIV_U     = 2'd0;
    localparam logic [PRIV_W-1:0] PRIV_S     = 2'd1;
    localparam logic [PRIV_W-1:0] PRIV_M_MIN = 2'd2;

    // Floating-point register window.
    localparam logic [ADDR_W-1:0] FP_FIRST = 12'h001;
    localparam logic [ADDR_W-1:0] FP_LAST  = 12'h003;

    // Counter windows (low halves, and high halves for 32-bit cores).
    localparam logic [ADDR_W-1:0] CNT_LO_BASE = 12'hC00;
    localparam logic [ADDR_W-1:0] CNT_HI_BASE = 12'hC80;

    // Address-translation register.
    localparam logic [ADDR_W-1:0] XLATE_ADDR = 12'h180;

    // Floating-point state field values.
    localparam logic [1:0] FS_OFF   = 2'b00;
    localparam logic [1:0] FS_DIRTY = 2'b11;

    // Reason codes, listed in priority order.
    typedef enum logic [1:0] {
        RSN_OK    = 2'd0,
        RSN_FP    = 2'd1,
        RSN_CNT   = 2'd2,
        RSN_XLATE = 2'd3
    } reason_e;

endpackage

// File: rtl/csr_addr_class.sv
// Module: csr_addr_class
// Sorts a register address into the rule sets the checker knows about.
// Assumes CNT_N is a power of two and the counter windows are aligned to CNT_N.
// The high counter window is recognised only when XLEN is 32.
module csr_addr_class
    import csr_perm_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int CNT_N = 32,
    localparam int IDX_W = $clog2(CNT_N)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              is_fp,
    output logic              is_cnt,
    output logic              is_xlate,
    output logic [IDX_W-1:0]  cnt_idx
);

    localparam int TOP_W = ADDR_W - IDX_W;

    localparam logic [TOP_W-1:0] LO_TOP = CNT_LO_BASE[ADDR_W-1:IDX_W];
    localparam logic [TOP_W-1:0] HI_TOP = CNT_HI_BASE[ADDR_W-1:IDX_W];

    logic lo_hit;
    logic hi_hit;

    // Floating-point and translation register matches.
    always_comb begin
        is_fp    = (addr >= FP_FIRST) && (addr <= FP_LAST);
        is_xlate = (addr == XLATE_ADDR);
    end

    // Low counter window match.
    always_comb lo_hit = (addr[ADDR_W-1:IDX_W] == LO_TOP);

    generate
        if (XLEN == 32) begin : g_hi_halves
            // High counter window match on 32-bit cores.
            always_comb hi_hit = (addr[ADDR_W-1:IDX_W] == HI_TOP);
        end else begin : g_no_hi_halves
            // Wider cores have no high-half counter registers.
            always_comb hi_hit = 1'b0;
        end
    endgenerate

    // Counter membership and the bit index into the enable masks.
    always_comb begin
        is_cnt  = lo_hit || hi_hit;
        cnt_idx = addr[IDX_W-1:0];
    end

endmodule

// File: rtl/csr_fp_gate.sv
// Module: csr_fp_gate
// Refuses a floating-point register access while floating-point state is off.
// Assumes the debugger flag is already qualified; it overrides the rule.
module csr_fp_gate
    import csr_perm_pkg::*;
(
    input  logic       is_fp,
    input  logic       dbg_access,
    input  logic [1:0] status_fs,
    output logic       fp_deny
);

    // Deny only when the unit is off and the debugger is not the requester.
    always_comb fp_deny = is_fp && !dbg_access && (status_fs == FS_OFF);

endmodule

// File: rtl/csr_cnt_gate.sv
// Module: csr_cnt_gate
// Builds the per-counter enable mask from the privilege level and refuses
// access to a counter whose mask bit is clear.
// Assumes a privilege value of 2 or 3 is machine and bypasses both masks.
module csr_cnt_gate
    import csr_perm_pkg::*;
#(
    parameter int CNT_N = 32,
    localparam int IDX_W = $clog2(CNT_N)
) (
    input  logic              is_cnt,
    input  logic [IDX_W-1:0]  cnt_idx,
    input  logic [PRIV_W-1:0] priv,
    input  logic [CNT_N-1:0]  mcnt_en,
    input  logic [CNT_N-1:0]  scnt_en,
    output logic              cnt_deny
);

    logic             below_m;
    logic             below_s;
    logic [CNT_N-1:0] en_mask;

    // Privilege comparisons shared by every mask bit.
    always_comb begin
        below_m = (priv < PRIV_M_MIN);
        below_s = (priv < PRIV_S);
    end

    generate
        for (genvar b = 0; b < CNT_N; b++) begin : g_mask
            // One mask bit: start enabled and remove by each applicable level.
            always_comb en_mask[b] = (mcnt_en[b] || !below_m) &&
                                     (scnt_en[b] || !below_s);
        end
    endgenerate

    // Deny when the selected counter is masked off.
    always_comb cnt_deny = is_cnt && !en_mask[cnt_idx];

endmodule

// File: rtl/csr_xlate_gate.sv
// Module: csr_xlate_gate
// Traps supervisor-mode access to the translation register when trapping is on.
// Assumes user-mode access to that register is handled by another rule elsewhere.
module csr_xlate_gate
    import csr_perm_pkg::*;
(
    input  logic              is_xlate,
    input  logic [PRIV_W-1:0] priv,
    input  logic              status_tvm,
    output logic              xlate_deny
);

    // Only the supervisor level is affected by the trap flag.
    always_comb xlate_deny = is_xlate && status_tvm && (priv == PRIV_S);

endmodule

// File: rtl/csr_perm_chk.sv
// Module: csr_perm_chk
// Top of the access permission checker. It classifies the address, runs the
// three rule gates, merges them in priority order and registers the verdict.
// Assumes inputs are stable around the rising edge. The result appears one
// cycle after the access.
module csr_perm_chk
    import csr_perm_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int CNT_N = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [PRIV_W-1:0] priv,
    input  logic              dbg_access,
    input  logic [1:0]        status_fs,
    input  logic              status_tvm,
    input  logic [CNT_N-1:0]  mcnt_en,
    input  logic [CNT_N-1:0]  scnt_en,
    output logic              chk_valid,
    output logic              chk_illegal,
    output logic [1:0]        chk_reason,
    output logic              fs_set_dirty
);

    localparam int IDX_W = $clog2(CNT_N);

    logic             is_fp;
    logic             is_cnt;
    logic             is_xlate;
    logic [IDX_W-1:0] cnt_idx;
    logic             fp_deny;
    logic             cnt_deny;
    logic             xlate_deny;
    reason_e          reason_d;
    logic             dirty_d;

    csr_addr_class #(.XLEN(XLEN), .CNT_N(CNT_N)) u_class (
        .addr     (acc_addr),
        .is_fp    (is_fp),
        .is_cnt   (is_cnt),
        .is_xlate (is_xlate),
        .cnt_idx  (cnt_idx)
    );

    csr_fp_gate u_fp (
        .is_fp      (is_fp),
        .dbg_access (dbg_access),
        .status_fs  (status_fs),
        .fp_deny    (fp_deny)
    );

    csr_cnt_gate #(.CNT_N(CNT_N)) u_cnt (
        .is_cnt   (is_cnt),
        .cnt_idx  (cnt_idx),
        .priv     (priv),
        .mcnt_en  (mcnt_en),
        .scnt_en  (scnt_en),
        .cnt_deny (cnt_deny)
    );

    csr_xlate_gate u_xlate (
        .is_xlate   (is_xlate),
        .priv       (priv),
        .status_tvm (status_tvm),
        .xlate_deny (xlate_deny)
    );

    // Priority merge of the rule verdicts for a valid access.
    always_comb begin
        reason_d = RSN_OK;
        if (acc_valid) begin
            if (fp_deny)         reason_d = RSN_FP;
            else if (cnt_deny)   reason_d = RSN_CNT;
            else if (xlate_deny) reason_d = RSN_XLATE;
        end
    end

    // A legal floating-point write marks the state dirty.
    always_comb dirty_d = acc_valid && acc_write && is_fp && !fp_deny;

    // Output register stage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_valid    <= 1'b0;
            chk_illegal  <= 1'b0;
            chk_reason   <= RSN_OK;
            fs_set_dirty <= 1'b0;
        end else begin
            chk_valid    <= acc_valid;
            chk_illegal  <= (reason_d != RSN_OK);
            chk_reason   <= reason_d;
            fs_set_dirty <= dirty_d;
        end
    end

    // R2
    fp_off_denied_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && is_fp && !dbg_access && status_fs == FS_OFF)
        |=> (chk_illegal && chk_reason == RSN_FP));

    // R3
    dbg_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && is_fp && dbg_access) |=> !chk_illegal);

    // R7
    machine_immune_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && priv >= PRIV_M_MIN)
        |=> (chk_reason != RSN_CNT && chk_reason != RSN_XLATE));

    // R8
    dirty_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fs_set_dirty |-> (chk_valid && !chk_illegal));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> (!chk_valid && !chk_illegal && !fs_set_dirty));

    // R9
    illegal_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_illegal |-> chk_valid);

endmodule

// File: tb/csr_perm_chk_tb.sv
module csr_perm_chk_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [11:0] acc_addr = '0;
    logic [1:0]  priv = '0;
    logic        dbg_access = 1'b0;
    logic [1:0]  status_fs = '0;
    logic        status_tvm = 1'b0;
    logic [31:0] mcnt_en = '0;
    logic [31:0] scnt_en = '0;
    logic        chk_valid;
    logic        chk_illegal;
    logic [1:0]  chk_reason;
    logic        fs_set_dirty;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    csr_perm_chk #(.XLEN(32), .CNT_N(32)) u_dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .priv(priv), .dbg_access(dbg_access),
        .status_fs(status_fs), .status_tvm(status_tvm), .mcnt_en(mcnt_en),
        .scnt_en(scnt_en), .chk_valid(chk_valid), .chk_illegal(chk_illegal),
        .chk_reason(chk_reason), .fs_set_dirty(fs_set_dirty)
    );

    // Expected reason code from the requirements (32-bit core).
    function automatic logic [1:0] exp_reason(
        input logic [11:0] a, input logic [1:0] p, input logic dbg,
        input logic [1:0] fs, input logic tvm,
        input logic [31:0] men, input logic [31:0] sen);
        logic [31:0] m;
        if (a >= 12'h001 && a <= 12'h003)
            return (!dbg && fs == 2'b00) ? 2'd1 : 2'd0;
        if ((a >= 12'hC00 && a <= 12'hC1F) || (a >= 12'hC80 && a <= 12'hC9F)) begin
            m = 32'hFFFF_FFFF;
            if (p == 2'd0 || p == 2'd1) m = m & men;
            if (p == 2'd0) m = m & sen;
            return m[a[4:0]] ? 2'd0 : 2'd2;
        end
        if (a == 12'h180 && p == 2'd1 && tvm) return 2'd3;
        return 2'd0;
    endfunction

    // Expected output word {valid, illegal, reason, dirty}.
    function automatic logic [4:0] exp_word(
        input logic v, input logic w, input logic [11:0] a, input logic [1:0] p,
        input logic dbg, input logic [1:0] fs, input logic tvm,
        input logic [31:0] men, input logic [31:0] sen);
        logic [1:0] r;
        logic d;
        if (!v) return 5'b0;
        r = exp_reason(a, p, dbg, fs, tvm, men, sen);
        d = w && (a >= 12'h001 && a <= 12'h003) && (r == 2'd0);
        return {1'b1, (r != 2'd0), r, d};
    endfunction

    task automatic compare(input string tag, input logic [4:0] exp);
        logic [4:0] act;
        act = {chk_valid, chk_illegal, chk_reason, fs_set_dirty};
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s addr=%h priv=%0d actual=%b expected=%b",
                     tag, acc_addr, priv, act, exp);
        end
    endtask

    // Drive one access on a falling edge, then check at the next falling edge.
    task automatic access(input string tag, input logic v, input logic w,
        input logic [11:0] a, input logic [1:0] p, input logic dbg,
        input logic [1:0] fs, input logic tvm,
        input logic [31:0] men, input logic [31:0] sen);
        logic [4:0] e;
        acc_valid = v; acc_write = w; acc_addr = a; priv = p; dbg_access = dbg;
        status_fs = fs; status_tvm = tvm; mcnt_en = men; scnt_en = sen;
        e = exp_word(v, w, a, p, dbg, fs, tvm, men, sen);
        @(negedge clk);
        compare(tag, e);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        @(negedge clk);
        // R1: outputs clear while held in reset
        acc_valid = 1'b1; acc_addr = 12'h001; status_fs = 2'b00;
        @(negedge clk);
        compare("R1", 5'b0);
        rst_n = 1'b1;

        // R2: FP off, plain access; R8: a read never sets dirty
        access("R2", 1, 1, 12'h001, 2'd3, 0, 2'b00, 0, '1, '1);
        access("R2", 1, 0, 12'h003, 2'd0, 0, 2'b00, 0, '1, '1);
        // R8: legal write with FS on sets dirty, read does not
        access("R8", 1, 1, 12'h002, 2'd0, 0, 2'b01, 0, '0, '0);
        access("R8", 1, 0, 12'h002, 2'd0, 0, 2'b10, 0, '0, '0);
        // R3: debugger bypass with FS off, write still sets dirty
        access("R3", 1, 1, 12'h003, 2'd1, 1, 2'b00, 0, '0, '0);
        // R4: counter masked only by the supervisor mask, at user level
        access("R4", 1, 0, 12'hC01, 2'd0, 0, 2'b11, 0, 32'h2, 32'h0);
        // R4: the same access at supervisor level ignores the supervisor mask
        access("R4", 1, 0, 12'hC01, 2'd1, 0, 2'b11, 0, 32'h2, 32'h0);
        // R4: machine mask clears index 31 at supervisor level
        access("R4", 1, 0, 12'hC1F, 2'd1, 0, 2'b11, 0, 32'h7FFF_FFFF, '1);
        // R5: high half at index 31
        access("R5", 1, 0, 12'hC9F, 2'd0, 0, 2'b11, 0, 32'h7FFF_FFFF, '1);
        access("R5", 1, 0, 12'hC85, 2'd0, 0, 2'b11, 0, '1, 32'h20);
        // R7: privilege encoding 2 and 3 bypass counter masks and trap flag
        access("R7", 1, 0, 12'hC00, 2'd2, 0, 2'b11, 0, '0, '0);
        access("R7", 1, 1, 12'h180, 2'd2, 0, 2'b11, 1, '0, '0);
        access("R7", 1, 0, 12'h180, 2'd3, 0, 2'b11, 1, '0, '0);
        // R6: supervisor trap, user not trapped, flag low not trapped
        access("R6", 1, 1, 12'h180, 2'd1, 0, 2'b11, 1, '1, '1);
        access("R6", 1, 1, 12'h180, 2'd0, 0, 2'b11, 1, '1, '1);
        access("R6", 1, 0, 12'h180, 2'd1, 0, 2'b11, 0, '1, '1);
        // R9: idle cycle, then an unrelated address, then a neighbouring one
        access("R9", 0, 1, 12'h001, 2'd0, 0, 2'b00, 0, '0, '0);
        access("R9", 1, 1, 12'h300, 2'd0, 0, 2'b00, 1, '0, '0);
        access("R9", 1, 0, 12'hC20, 2'd0, 0, 2'b00, 0, '0, '0);

        // Constrained random traffic across all address classes
        for (int i = 0; i < 600; i++) begin
            logic [11:0] a;
            logic [1:0] p;
            string tag;
            p = 2'($urandom_range(0, 3));
            case ($urandom_range(0, 4))
                0: begin a = 12'($urandom_range(1, 3)); tag = "R2"; end
                1: begin a = 12'hC00 | 12'($urandom_range(0, 31)); tag = "R4"; end
                2: begin a = 12'hC80 | 12'($urandom_range(0, 31)); tag = "R5"; end
                3: begin a = 12'h180; tag = "R6"; end
                default: begin a = 12'($urandom); tag = "R9"; end
            endcase
            if (p >= 2'd2 && tag != "R2") tag = "R7";
            access(tag, ($urandom_range(0, 7) != 0), 1'($urandom), a, p,
                   1'($urandom), 2'($urandom), 1'($urandom), $urandom, $urandom);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule